// File: doc/BRIEF.md
# Tag Range Checker

This block decides whether a memory access may proceed by comparing the 4-bit tag held in a pointer with the allocation tags of every 16-byte granule that the access covers. The caller gives the access address, the access length minus one (up to 256 bytes) and the pointer tag. The block then walks a packed tag store through a synchronous read port, one byte per request. Each byte holds two granule tags: bits 3:0 hold the tag for the even granule and bits 7:4 hold the tag for the odd granule.

The walk stops at the first granule whose tag differs from the pointer tag. A one-cycle done strobe then presents three results:
- a pass flag;
- the number of granules that matched before the walk stopped;
- a fault address, which is the address of the first byte of the failing granule, or the access address itself when the very first granule fails.

A bypass input covers pointers whose tag checking is disabled. For such a pointer the block reports a pass at once and makes no tag reads. Address translation is handled outside the block. The tag port addresses one contiguous tag region, and the byte index on that port is the address divided by 32.

Top module: `tag_range_checker`

## Requirements
- R1: The number of granules checked is ((addr+size_m1)>>4) − (addr>>4) + 1. When every one of them carries the pointer tag, the result is pass, the match count equals that number, and the fault address equals the access address.
- R2: Granule g is looked up in tag byte g>>1, and the byte index on the read port is the address shifted right by 5. Even granules use bits 3:0 of the byte and odd granules use bits 7:4.
- R3: When bit 4 of the access address is set, the walk starts on bits 7:4 of the first byte, and bits 3:0 of that byte have no effect on the result.
- R4: The walk stops at the first mismatching granule and reports the number of granules matched before it. No tag byte beyond the one holding the failing granule is requested.
- R5: When the first granule fails, the match count is 0 and the fault address is the unmodified access address.
- R6: When a later granule fails, the fault address is the access address rounded down to a multiple of 16, plus 16 times the match count, so its low four bits are zero.
- R7: When bypass is set with a start, done follows one cycle later with pass set, a match count of 0 and the fault address equal to the access address. No tag read is issued, whatever the tag memory holds.
- R8: Tag bytes are read with a one-cycle latency. There is one request per byte, requests are made only while busy, and each request after the first in a walk addresses the next byte index.
- R9: Done is a single-cycle pulse. The results hold their values until the next done. A start while busy is ignored.
- R10: After reset, busy, done, the read request, pass and the match count are all 0.
- R11: An access of the maximum length (size_m1 = 255) starting off a granule boundary checks 17 granules, and the match count never exceeds the granule total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a check (taken only when idle) |
| bypass_i | input | 1 | Tag checking disabled for this pointer |
| addr_i | input | ADDR_W | Access start address |
| size_m1_i | input | SIZE_W | Access length in bytes minus one |
| ptr_tag_i | input | 4 | Tag carried by the pointer |
| busy_o | output | 1 | A walk is in progress |
| mem_req_o | output | 1 | Tag byte read request |
| mem_addr_o | output | ADDR_W-5 | Tag byte index |
| mem_rdata_i | input | 8 | Tag byte, valid the cycle after the request |
| done_o | output | 1 | Result strobe |
| pass_o | output | 1 | All checked granules matched |
| match_cnt_o | output | CNT_W | Granules matched before the stop |
| fault_addr_o | output | ADDR_W | Address reported for the failing granule |

## Verification
The embedded assertions check, on every cycle:
- that done is a single-cycle pulse and that read requests occur only while busy;
- that successive requests step through consecutive byte indices;
- that a bypassed start yields done with no read;
- that a failing result always reports fewer matches than the total;
- that a fault address past the first granule is aligned to 16 bytes;
- that the running count stays below the total.

Which nibble holds which granule's tag, that the lower nibble is skipped on an odd start, the exact match counts and fault addresses, and the early stop in the number of bytes fetched all depend on memory contents. Only the scoreboard scenarios can show these, because they compare each result against a model of the tag store.

// File: rtl/tag_range_pkg.sv
package tag_range_pkg;
  localparam int TAG_W   = 4;
  localparam int GRAN_LG = 4;              // 16-byte granule
  localparam int BYTE_LG = GRAN_LG + 1;    // two granules per tag byte
  localparam int NIB_N   = 8 / TAG_W;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_CHECK = 2'd2
  } walk_st_e;
endpackage

// File: rtl/tag_range_span.sv
module tag_range_span
  import tag_range_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 5,
  localparam int IDX_W = ADDR_W - BYTE_LG,
  localparam int GID_W = ADDR_W - GRAN_LG
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_m1_i,
  output logic [CNT_W-1:0]  total_o,
  output logic [IDX_W-1:0]  first_idx_o,
  output logic              odd_o
);
  logic [ADDR_W-1:0] last_addr;
  logic [GID_W-1:0]  gid_diff;

  always_comb begin
    last_addr   = addr_i + ADDR_W'(size_m1_i);
    gid_diff    = last_addr[ADDR_W-1:GRAN_LG] - addr_i[ADDR_W-1:GRAN_LG];
    total_o     = gid_diff[CNT_W-1:0] + CNT_W'(1);
    first_idx_o = addr_i[ADDR_W-1:BYTE_LG];
    odd_o       = addr_i[GRAN_LG];
  end
endmodule

// File: rtl/tag_range_nibble_cmp.sv
module tag_range_nibble_cmp
  import tag_range_pkg::*;
(
  input  logic [7:0]       byte_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [NIB_N-1:0] ok_o
);
  logic [7:0] diff;

  assign diff = byte_i ^ {NIB_N{tag_i}};

  for (genvar n = 0; n < NIB_N; n++) begin : g_nib
    assign ok_o[n] = (diff[n*TAG_W +: TAG_W] == '0);
  end
endmodule

// File: rtl/tag_range_fault.sv
module tag_range_fault
  import tag_range_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  match_cnt_i,
  output logic [ADDR_W-1:0] fault_o
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    base = {addr_i[ADDR_W-1:GRAN_LG], GRAN_LG'(0)};
    if (match_cnt_i == '0) fault_o = addr_i;
    else                   fault_o = base + (ADDR_W'(match_cnt_i) << GRAN_LG);
  end
endmodule

// File: rtl/tag_range_checker.sv
module tag_range_checker
  import tag_range_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MAX_BYTES = 256,
  localparam int SIZE_W   = $clog2(MAX_BYTES),
  localparam int CNT_W    = $clog2(MAX_BYTES / (1 << GRAN_LG) + 2),
  localparam int IDX_W    = ADDR_W - BYTE_LG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bypass_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_m1_i,
  input  logic [TAG_W-1:0]  ptr_tag_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [IDX_W-1:0]  mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              done_o,
  output logic              pass_o,
  output logic [CNT_W-1:0]  match_cnt_o,
  output logic [ADDR_W-1:0] fault_addr_o
);
  walk_st_e          st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  tag_q;
  logic [CNT_W-1:0]  total_q, cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              odd_q;
  logic              done_q, pass_q;
  logic [CNT_W-1:0]  res_cnt_q;
  logic [ADDR_W-1:0] fault_q;

  logic [CNT_W-1:0]  span_total;
  logic [IDX_W-1:0]  span_idx;
  logic              span_odd;
  logic [NIB_N-1:0]  nib_ok;
  logic [CNT_W-1:0]  remain, nxt_cnt;
  logic              fin, fin_pass;
  logic [ADDR_W-1:0] fault_w;

  tag_range_span #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_span (
    .addr_i      (addr_i),
    .size_m1_i   (size_m1_i),
    .total_o     (span_total),
    .first_idx_o (span_idx),
    .odd_o       (span_odd)
  );

  tag_range_nibble_cmp u_cmp (
    .byte_i (mem_rdata_i),
    .tag_i  (tag_q),
    .ok_o   (nib_ok)
  );

  tag_range_fault #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fault (
    .addr_i      (addr_q),
    .match_cnt_i (nxt_cnt),
    .fault_o     (fault_w)
  );

  // Per-byte decision: up to two granules resolved per fetched byte
  always_comb begin
    remain   = total_q - cnt_q;
    nxt_cnt  = cnt_q;
    fin      = 1'b0;
    fin_pass = 1'b0;
    if (!odd_q) begin
      if (!nib_ok[0]) begin
        fin = 1'b1;
      end else if (remain == CNT_W'(1)) begin
        nxt_cnt  = cnt_q + CNT_W'(1);
        fin      = 1'b1;
        fin_pass = 1'b1;
      end else if (!nib_ok[1]) begin
        nxt_cnt = cnt_q + CNT_W'(1);
        fin     = 1'b1;
      end else begin
        nxt_cnt  = cnt_q + CNT_W'(2);
        fin      = (remain == CNT_W'(2));
        fin_pass = fin;
      end
    end else begin
      if (!nib_ok[1]) begin
        fin = 1'b1;
      end else begin
        nxt_cnt  = cnt_q + CNT_W'(1);
        fin      = (remain == CNT_W'(1));
        fin_pass = fin;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      addr_q    <= '0;
      tag_q     <= '0;
      total_q   <= '0;
      cnt_q     <= '0;
      idx_q     <= '0;
      odd_q     <= 1'b0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      res_cnt_q <= '0;
      fault_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            addr_q <= addr_i;
            tag_q  <= ptr_tag_i;
            if (bypass_i) begin
              done_q    <= 1'b1;
              pass_q    <= 1'b1;
              res_cnt_q <= '0;
              fault_q   <= addr_i;
            end else begin
              total_q <= span_total;
              cnt_q   <= '0;
              idx_q   <= span_idx;
              odd_q   <= span_odd;
              st_q    <= ST_FETCH;
            end
          end
        end
        ST_FETCH: st_q <= ST_CHECK;
        ST_CHECK: begin
          if (fin) begin
            done_q    <= 1'b1;
            pass_q    <= fin_pass;
            res_cnt_q <= nxt_cnt;
            fault_q   <= fin_pass ? addr_q : fault_w;
            st_q      <= ST_IDLE;
          end else begin
            cnt_q <= nxt_cnt;
            idx_q <= idx_q + IDX_W'(1);
            odd_q <= 1'b0;
            st_q  <= ST_FETCH;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign mem_req_o    = (st_q == ST_FETCH);
  assign mem_addr_o   = idx_q;
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign match_cnt_o  = res_cnt_q;
  assign fault_addr_o = fault_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_REQ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o); // R8
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(st_q) == ST_CHECK) |-> mem_addr_o == $past(mem_addr_o) + IDX_W'(1)); // R8
  AST_BYP_NOREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && bypass_i && !busy_o) |=> (done_o && pass_o && !mem_req_o && !busy_o)); // R7
  AST_FAIL_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> match_cnt_o < total_q); // R4
  AST_FAULT_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o && match_cnt_o != '0) |-> fault_addr_o[GRAN_LG-1:0] == '0); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q < total_q); // R11
endmodule

// File: tb/tag_range_checker_test.sv
`timescale 1ns/1ps
module tag_range_checker_test;
  localparam int ADDR_W = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, bypass = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  size_m1 = '0;
  logic [3:0]  ptag = '0;
  logic        busy, mem_req, done, pass;
  logic [26:0] mem_addr;
  logic [7:0]  rdata = '0;
  logic [4:0]  mcnt;
  logic [31:0] faddr;

  int checks = 0, errors = 0;

  typedef struct {
    logic pass;
    int   cnt;
    int   fault;
    int   nreq;
    int   fidx;
  } exp_t;
  exp_t  exp_q[$];
  string lbl_q[$];
  logic [7:0] tmem [64];

  always #10 clk = ~clk;

  tag_range_checker #(.ADDR_W(ADDR_W), .MAX_BYTES(256)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bypass_i(bypass),
    .addr_i(addr), .size_m1_i(size_m1), .ptr_tag_i(ptag), .busy_o(busy),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(rdata),
    .done_o(done), .pass_o(pass), .match_cnt_o(mcnt), .fault_addr_o(faddr)
  );

  // synchronous tag store model
  always @(posedge clk) if (mem_req) rdata <= tmem[mem_addr[5:0]];

  task automatic chk(string lbl, string what, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", lbl, what, act, expv);
    end
  endtask

  task automatic set_gran(int g, logic [3:0] t);
    if (g[0]) tmem[g >> 1][7:4] = t;
    else      tmem[g >> 1][3:0] = t;
  endtask

  // monitor
  int  req_n = 0;
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_prev && done) chk("R9", "done width", 2, 1);
      done_prev = done;
      if (mem_req) begin
        if (req_n == 0 && exp_q.size() > 0)
          chk(lbl_q[0], "first byte index", mem_addr, exp_q[0].fidx);
        req_n++;
      end
      if (done) begin
        if (exp_q.size() == 0) begin
          chk("R9", "unexpected done", 1, 0);
        end else begin
          exp_t e;
          string l;
          e = exp_q.pop_front();
          l = lbl_q.pop_front();
          chk(l, "pass", pass, e.pass);
          chk(l, "match count", mcnt, e.cnt);
          chk(l, "fault addr", faddr, e.fault);
          chk(l, "tag reads", req_n, e.nreq);
        end
        req_n = 0;
      end
    end
  end

  // driver: computes expectation from the tag store model, then starts
  task automatic run(string lbl, int a, int sm1, logic [3:0] t, logic byp);
    exp_t e;
    int fg, lg, c;
    bit fail;
    fg = a >> 4;
    lg = (a + sm1) >> 4;
    c = 0;
    fail = 0;
    for (int g = fg; g <= lg; g++) begin
      logic [3:0] nib;
      nib = g[0] ? tmem[(g >> 1) & 63][7:4] : tmem[(g >> 1) & 63][3:0];
      if (nib != t) begin fail = 1; break; end
      c++;
    end
    if (byp) begin
      e = '{pass: 1'b1, cnt: 0, fault: a, nreq: 0, fidx: 0};
    end else begin
      e.pass  = !fail;
      e.cnt   = c;
      e.fault = (!fail || c == 0) ? a : ((fg << 4) + 16 * c);
      e.nreq  = fail ? (((fg + c) >> 1) - (fg >> 1) + 1) : ((lg >> 1) - (fg >> 1) + 1);
      e.fidx  = fg >> 1;
    end
    exp_q.push_back(e);
    lbl_q.push_back(lbl);
    @(negedge clk);
    addr = a; size_m1 = sm1[7:0]; ptag = t; bypass = byp; start = 1'b1;
    @(negedge clk);
    start = 1'b0; bypass = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) tmem[i] = 8'hff;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "busy", busy, 0);
    chk("R10", "done", done, 0);
    chk("R10", "mem_req", mem_req, 0);
    chk("R10", "pass", pass, 0);
    chk("R10", "match count", mcnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2: single aligned granule, even nibble
    set_gran(0, 4'h5); set_gran(1, 4'h3);
    run("R2", 32'h000, 15, 4'h5, 1'b0); wait_idle();
    // R3: odd start, lower nibble differs but is skipped
    set_gran(0, 4'h3); set_gran(1, 4'h7);
    run("R3", 32'h010, 15, 4'h7, 1'b0); wait_idle();
    // R3: one byte at end of odd granule
    run("R3", 32'h01f, 0, 4'h7, 1'b0); wait_idle();
    // R1: two-byte access straddling granules 0 and 1
    set_gran(0, 4'h7);
    run("R1", 32'h00f, 1, 4'h7, 1'b0); wait_idle();
    // R1: five granules, all match
    for (int g = 4; g <= 8; g++) set_gran(g, 4'h9);
    run("R1", 32'h048, 63, 4'h9, 1'b0); wait_idle();
    // R5: first granule fails
    set_gran(16, 4'h2);
    run("R5", 32'h105, 31, 4'h9, 1'b0); wait_idle();
    // R4 R6: third granule fails, no further bytes fetched
    set_gran(32, 4'ha); set_gran(33, 4'ha); set_gran(34, 4'hb);
    set_gran(35, 4'ha); set_gran(36, 4'ha);
    run("R4", 32'h205, 63, 4'ha, 1'b0); wait_idle();
    // R6 R3: odd start, failure on an odd granule of a later byte
    set_gran(49, 4'hc); set_gran(50, 4'hc); set_gran(51, 4'h1); set_gran(52, 4'hc);
    run("R6", 32'h31c, 40, 4'hc, 1'b0); wait_idle();
    // R11: maximum length, 17 granules
    for (int g = 64; g <= 80; g++) set_gran(g, 4'he);
    run("R11", 32'h408, 255, 4'he, 1'b0); wait_idle();
    // R11 R6: maximum length, last granule fails
    set_gran(80, 4'h0);
    run("R11", 32'h408, 255, 4'he, 1'b0); wait_idle();
    // R7: bypass over mismatching tags
    run("R7", 32'h105, 31, 4'h9, 1'b1); wait_idle();
    // R9: start while busy is ignored
    run("R9", 32'h048, 63, 4'h9, 1'b0);
    repeat (2) @(negedge clk);
    addr = 32'h700; bypass = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; bypass = 1'b0;
    wait_idle();
    repeat (4) @(negedge clk);
    // R9: results held after done
    chk("R9", "held pass", pass, 1);
    chk("R9", "held count", mcnt, 5);
    chk("R9", "queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule